// File: doc/BRIEF.md
# PWM Downlink Configuration Receiver

This block turns a pulse-width-modulated serial stream into configuration words for a small sensing device. The stream arrives as a single-bit level already recovered and made synchronous to the device's recovered clock. Each symbol starts with a rising edge. The length of the high part picks the bit value. Decoded bits pass through an 18-bit sliding window. That window is compared against two addresses: a broadcast code that is fixed in hardware and identical on every device, and a per-device code built from an 8-bit fixed prefix followed by the device's 10-bit identifier.

When the window matches either code, the next 19 decoded bits are collected as a configuration word. When the last of those bits arrives, the word is loaded into the configuration register and a one-cycle `valid` pulse is issued. The two gain fields of the register are also brought out on ports of their own. A stream that goes quiet for too long aborts any partial frame and any partial address match. The register then keeps its previous contents.

Top module: `cfgrx_top`

## Requirements
- R1: After a synchronous reset, `cfg` holds the default word 19'h44000, `amp_gain` reads 4, `fe_gain` reads 2 and `valid` is low.
- R2: A symbol is a run of high samples followed by low samples. A high run longer than SYM_CYC/2 clock cycles decodes as 1, otherwise as 0. With SYM_CYC = 8, a 4-cycle high run is 0 and a 5-cycle high run is 1. Bits are taken most significant first.
- R3: The 18-bit broadcast code 18'h3A5C6 followed by 19 bits loads those 19 bits into `cfg`, the first received bit landing in bit 18.
- R4: The per-device code {8'hB4, dev_id} followed by 19 bits loads those bits into `cfg` in the same way.
- R5: A per-device code that carries an identifier other than `dev_id` is ignored: `cfg` keeps its value and `valid` stays low.
- R6: Address matching runs on a sliding window, so a code preceded by any number of other bits is still found.
- R7: `valid` is high for exactly one cycle per accepted frame. It rises on the second clock edge after the first low sample that ends the last configuration bit. `cfg` changes only in that cycle.
- R8: A low run of more than IDLE_SYMS*SYM_CYC samples aborts a frame in capture and clears a partial address match. A low run of exactly IDLE_SYMS*SYM_CYC samples aborts nothing.
- R9: `amp_gain` always equals `cfg[18:16]` and `fe_gain` always equals `cfg[15:13]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Synchronous PWM serial stream |
| dev_id | input | 10 | Device identifier used in the per-device code |
| valid | output | 1 | One-cycle pulse when a configuration word is loaded |
| cfg | output | 19 | Configuration register |
| amp_gain | output | 3 | Amplifier gain field of the register |
| fe_gain | output | 3 | Feature-extractor gain field of the register |

## Verification
The bench builds the block with SYM_CYC = 8 and IDLE_SYMS = 4. This keeps a full 37-bit frame within a few hundred cycles, so many frames fit in one run. It also puts the decision threshold at 4/5 high cycles and the abort limit at 32/33 low samples. Both boundaries can then be driven exactly from either side. A behavioural model built from queues is compared with `valid` and `cfg` on every cycle. Directed frames cover both address codes, a foreign identifier, prefixed garbage and both sides of the idle limit, in capture and during an address match.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    localparam int CODE_W = 18;
    localparam int ID_W   = 10;
    localparam int PRE_W  = CODE_W - ID_W;
    localparam int GAIN_W = 3;
    localparam int RSV_W  = 13;
    localparam int CFG_W  = 2 * GAIN_W + RSV_W;
    localparam int N_CODES = 2;

    localparam logic [CODE_W-1:0] BCAST_CODE = 18'h3A5C6;
    localparam logic [PRE_W-1:0]  DEV_PREFIX = 8'hB4;

    typedef struct packed {
        logic [GAIN_W-1:0] amp;
        logic [GAIN_W-1:0] fe;
        logic [RSV_W-1:0]  rsv;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{amp: 3'd4, fe: 3'd2, rsv: '0};

    typedef struct packed {
        logic stb;
        logic val;
    } sym_t;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_CAPT = 1'b1
    } rx_state_e;

    function automatic logic [CODE_W-1:0] dev_code(input logic [ID_W-1:0] id);
        return {DEV_PREFIX, id};
    endfunction

endpackage

// File: rtl/cfgrx_sym_dec.sv
module cfgrx_sym_dec
    import cfgrx_pkg::*;
#(
    parameter int SYM_CYC   = 32,
    parameter int IDLE_SYMS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output sym_t sym,
    output logic idle_to
);

    localparam int HALF     = SYM_CYC / 2;
    localparam int IDLE_LIM = IDLE_SYMS * SYM_CYC + 1;
    localparam int HCNT_W   = $clog2(2 * SYM_CYC + 1);
    localparam int ICNT_W   = $clog2(IDLE_LIM + 1);

    localparam logic [HCNT_W-1:0] HI_MAX    = '1;
    localparam logic [HCNT_W-1:0] HALF_V    = HCNT_W'(HALF);
    localparam logic [HCNT_W-1:0] HI_ONE    = HCNT_W'(1);
    localparam logic [ICNT_W-1:0] IDLE_LAST = ICNT_W'(IDLE_LIM - 1);
    localparam logic [ICNT_W-1:0] IDLE_SAT  = ICNT_W'(IDLE_LIM);

    logic              pin_q;
    logic [HCNT_W-1:0] hi_cnt;
    logic [ICNT_W-1:0] lo_cnt;
    logic              fall;

    assign fall = pin_q & ~pwm_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= 1'b0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            sym     <= '0;
            idle_to <= 1'b0;
        end else begin
            pin_q   <= pwm_in;
            sym.stb <= fall;
            sym.val <= fall && (hi_cnt > HALF_V);
            idle_to <= !pwm_in && (lo_cnt == IDLE_LAST);
            if (pwm_in) begin
                lo_cnt <= '0;
                if (!pin_q) begin
                    hi_cnt <= HI_ONE;
                end else if (hi_cnt != HI_MAX) begin
                    hi_cnt <= hi_cnt + 1'b1;
                end
            end else if (lo_cnt != IDLE_SAT) begin
                lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgrx_match.sv
module cfgrx_match
    import cfgrx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            clr,
    input  logic            bit_in,
    input  logic [ID_W-1:0] dev_id,
    output logic            hit
);

    localparam int FILL_W = $clog2(CODE_W + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(CODE_W);
    localparam logic [FILL_W-1:0] FILL_NEAR = FILL_W'(CODE_W - 1);

    logic [CODE_W-1:0] win;
    logic [CODE_W-1:0] win_nxt;
    logic [FILL_W-1:0] fill;
    logic [CODE_W-1:0] codes [N_CODES];
    logic [N_CODES-1:0] hits;

    assign win_nxt = {win[CODE_W-2:0], bit_in};

    always_comb begin
        codes[0] = BCAST_CODE;
        codes[1] = dev_code(dev_id);
    end

    for (genvar i = 0; i < N_CODES; i++) begin : g_cmp
        assign hits[i] = (win_nxt == codes[i]);
    end

    assign hit = (fill >= FILL_NEAR) && (|hits);

    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            fill <= '0;
        end else if (clr) begin
            win  <= '0;
            fill <= '0;
        end else if (shift_en) begin
            win <= win_nxt;
            if (fill != FILL_FULL) begin
                fill <= fill + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgrx_capture.sv
module cfgrx_capture
    import cfgrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sym_t      sym,
    input  logic      idle_to,
    input  logic      hit,
    output logic      win_shift,
    output logic      win_clr,
    output rx_state_e state,
    output logic      valid,
    output cfg_t      cfg
);

    localparam int CNT_W = $clog2(CFG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CFG_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [CFG_W-1:0] shreg;
    logic [CFG_W-1:0] word_nxt;

    assign win_shift = sym.stb && (state == ST_HUNT) && !idle_to;
    assign win_clr   = idle_to || (win_shift && hit);
    assign word_nxt  = {shreg[CFG_W-2:0], sym.val};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            cnt   <= '0;
            shreg <= '0;
            valid <= 1'b0;
            cfg   <= CFG_DEFAULT;
        end else begin
            valid <= 1'b0;
            if (idle_to) begin
                state <= ST_HUNT;
                cnt   <= '0;
            end else if (sym.stb) begin
                if (state == ST_HUNT) begin
                    if (hit) begin
                        state <= ST_CAPT;
                        cnt   <= '0;
                    end
                end else begin
                    shreg <= word_nxt;
                    if (cnt == CNT_LAST) begin
                        cfg   <= cfg_t'(word_nxt);
                        valid <= 1'b1;
                        state <= ST_HUNT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top
    import cfgrx_pkg::*;
#(
    parameter int SYM_CYC   = 32,
    parameter int IDLE_SYMS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic [ID_W-1:0]  dev_id,
    output logic             valid,
    output logic [CFG_W-1:0] cfg,
    output logic [GAIN_W-1:0] amp_gain,
    output logic [GAIN_W-1:0] fe_gain
);

    sym_t      sym;
    logic      idle_to;
    logic      hit;
    logic      win_shift;
    logic      win_clr;
    rx_state_e state;
    cfg_t      cfg_q;
    logic      capt;

    cfgrx_sym_dec #(
        .SYM_CYC  (SYM_CYC),
        .IDLE_SYMS(IDLE_SYMS)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .sym    (sym),
        .idle_to(idle_to)
    );

    cfgrx_match u_match (
        .clk     (clk),
        .rst     (rst),
        .shift_en(win_shift),
        .clr     (win_clr),
        .bit_in  (sym.val),
        .dev_id  (dev_id),
        .hit     (hit)
    );

    cfgrx_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .sym      (sym),
        .idle_to  (idle_to),
        .hit      (hit),
        .win_shift(win_shift),
        .win_clr  (win_clr),
        .state    (state),
        .valid    (valid),
        .cfg      (cfg_q)
    );

    assign capt     = (state == ST_CAPT);
    assign cfg      = cfg_q;
    assign amp_gain = cfg_q.amp;
    assign fe_gain  = cfg_q.fe;

endmodule

// File: rtl/cfgrx_chk.sv
module cfgrx_chk (
    input logic        clk,
    input logic        rst,
    input logic        pwm_in,
    input logic        sym_stb,
    input logic        idle_to,
    input logic        hit,
    input logic        capt,
    input logic        valid,
    input logic [18:0] cfg
);

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(cfg));

    a_r7_valid_after_bit: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($past(sym_stb) && $past(capt)));

    a_r2_strobe_on_fall: assert property (@(posedge clk) disable iff (rst)
        sym_stb |-> (!$past(pwm_in) && $past(pwm_in, 2)));

    a_r3_match_enters_capture: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && !capt && hit && !idle_to) |=> capt);

    a_r8_timeout_aborts: assert property (@(posedge clk) disable iff (rst)
        idle_to |=> (!capt && !valid));

endmodule

bind cfgrx_top cfgrx_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .sym_stb(sym.stb),
    .idle_to(idle_to),
    .hit    (hit),
    .capt   (capt),
    .valid  (valid),
    .cfg    (cfg)
);

// File: tb/tb_cfgrx_top.sv
module tb_cfgrx_top;

    localparam int SYM = 8;
    localparam int IDL = 4;
    localparam int HALF = SYM / 2;
    localparam int LIM = IDL * SYM + 1;
    localparam logic [17:0] G_CODE = 18'h3A5C6;
    localparam logic [9:0]  MY_ID = 10'h2A5;
    localparam logic [17:0] L_CODE = {8'hB4, MY_ID};
    localparam logic [17:0] X_CODE = {8'hB4, 10'h15A};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_in = 1'b0;
    logic [9:0]  dev_id = MY_ID;
    logic        valid;
    logic [18:0] cfg;
    logic [2:0]  amp_gain;
    logic [2:0]  fe_gain;

    int tests = 0;
    int fails = 0;
    int vcount = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfgrx_top #(.SYM_CYC(SYM), .IDLE_SYMS(IDL)) dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .dev_id(dev_id),
        .valid(valid), .cfg(cfg), .amp_gain(amp_gain), .fe_gain(fe_gain)
    );

    // behavioural reference model
    int hi_run, lo_run;
    bit prev, pend_b, pend_v, pend_to, m_capt, m_valid;
    bit q_win[$];
    bit q_cfg[$];
    logic [18:0] m_cfg;

    function automatic logic [17:0] win_val();
        logic [17:0] v = '0;
        foreach (q_win[i]) v = {v[16:0], q_win[i]};
        return v;
    endfunction

    function automatic logic [18:0] cfg_val();
        logic [18:0] v = '0;
        foreach (q_cfg[i]) v = {v[17:0], q_cfg[i]};
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hi_run = 0; lo_run = 0; prev = 0; pend_b = 0; pend_v = 0;
            pend_to = 0; m_capt = 0; m_valid = 0; m_cfg = 19'h44000;
            q_win.delete(); q_cfg.delete();
        end else begin
            m_valid = 0;
            if (pend_to) begin
                m_capt = 0; q_win.delete(); q_cfg.delete();
            end else if (pend_b) begin
                if (!m_capt) begin
                    q_win.push_back(pend_v);
                    if (q_win.size() > 18) void'(q_win.pop_front());
                    if (q_win.size() == 18 &&
                        (win_val() == G_CODE || win_val() == {8'hB4, dev_id})) begin
                        m_capt = 1; q_win.delete(); q_cfg.delete();
                    end
                end else begin
                    q_cfg.push_back(pend_v);
                    if (q_cfg.size() == 19) begin
                        m_cfg = cfg_val(); m_valid = 1; m_capt = 0; q_cfg.delete();
                    end
                end
            end
            pend_b = 0; pend_to = 0;
            if (pwm_in) begin
                lo_run = 0;
                hi_run = prev ? hi_run + 1 : 1;
            end else begin
                if (prev) begin pend_b = 1; pend_v = (hi_run > HALF); end
                lo_run++;
                if (lo_run == LIM) pend_to = 1;
            end
            prev = pwm_in;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (valid !== m_valid) begin
                fails++;
                $display("FAIL R7 valid per-cycle: actual %b expected %b at %0t", valid, m_valid, $time);
            end
            tests++;
            if (cfg !== m_cfg) begin
                fails++;
                $display("FAIL R3 cfg per-cycle: actual %h expected %h at %0t", cfg, m_cfg, $time);
            end
            tests++;
            if (amp_gain !== cfg[18:16] || fe_gain !== cfg[15:13]) begin
                fails++;
                $display("FAIL R9 gain fields: actual %h/%h expected %h/%h", amp_gain, fe_gain, cfg[18:16], cfg[15:13]);
            end
            if (valid === 1'b1) vcount++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sym(input bit b, input int hi, input int lo);
        repeat (hi) begin @(negedge clk); pwm_in = 1'b1; end
        repeat (lo) begin @(negedge clk); pwm_in = 1'b0; end
    endtask

    task automatic send(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sym(v[i], v[i] ? 6 : 2, v[i] ? 2 : 6);
    endtask

    task automatic send_last_lo(input logic [63:0] v, input int n, input int lastlo);
        for (int i = n - 1; i >= 1; i--) sym(v[i], v[i] ? 6 : 2, v[i] ? 2 : 6);
        sym(v[0], v[0] ? 6 : 2, lastlo);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); pwm_in = 1'b0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int vc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        chk("R1 cfg default", 32'(cfg), 32'h44000);
        chk("R1 valid low", 32'(valid), 0);
        chk("R9 amp default", 32'(amp_gain), 4);
        chk("R9 fe default", 32'(fe_gain), 2);

        // R3 broadcast frame
        vc = vcount;
        send(64'(G_CODE), 18); send(64'h5A3C1, 19); idle(6);
        chk("R3 broadcast load", 32'(cfg), 32'h5A3C1);
        chk("R9 amp field", 32'(amp_gain), 32'h5);
        chk("R7 one pulse", 32'(vcount - vc), 1);

        // R4 per-device frame
        vc = vcount;
        send(64'(L_CODE), 18); send(64'h1B2E7, 19); idle(6);
        chk("R4 device load", 32'(cfg), 32'h1B2E7);
        chk("R7 one pulse dev", 32'(vcount - vc), 1);

        // R5 foreign identifier
        vc = vcount;
        send(64'(X_CODE), 18); send(64'h7FFFF, 19); idle(6);
        chk("R5 foreign ignored", 32'(cfg), 32'h1B2E7);
        chk("R5 no pulse", 32'(vcount - vc), 0);

        // R6 prefixed garbage
        send(64'h15, 5); send(64'(G_CODE), 18); send(64'h40A05, 19); idle(6);
        chk("R6 sliding window", 32'(cfg), 32'h40A05);

        // R2 boundary widths: 4 high -> 0, 5 high -> 1
        for (int i = 17; i >= 0; i--) sym(G_CODE[i], G_CODE[i] ? 5 : 4, 4);
        for (int i = 18; i >= 0; i--) sym(i[0], i[0] ? 5 : 4, 4);
        idle(6);
        chk("R2 threshold decode", 32'(cfg), 32'h2AAAA);

        // R8 abort in capture: low run of 33
        send(64'(G_CODE), 18); send_last_lo(64'h55, 7, LIM); send(64'h123, 12); idle(6);
        chk("R8 abort keeps cfg", 32'(cfg), 32'h2AAAA);

        // R8 no abort at exactly 32
        send(64'(G_CODE), 18); send_last_lo(64'h55, 7, LIM - 1); send(64'h123, 12); idle(6);
        chk("R8 limit not exceeded", 32'(cfg), 32'h55123);

        // R8 partial address match cleared
        send_last_lo(64'(G_CODE >> 8), 10, LIM); send(64'(G_CODE & 18'hFF), 8);
        send(64'h0F0F0, 19); idle(6);
        chk("R8 window cleared", 32'(cfg), 32'h55123);

        // R8 partial match survives exactly 32
        send_last_lo(64'(G_CODE >> 8), 10, LIM - 1); send(64'(G_CODE & 18'hFF), 8);
        send(64'h0F0F0, 19); idle(6);
        chk("R8 window kept", 32'(cfg), 32'h0F0F0);

        // back-to-back frames
        vc = vcount;
        send(64'(L_CODE), 18); send(64'h3C3C3, 19);
        send(64'(G_CODE), 18); send(64'h00001, 19); idle(6);
        chk("R7 two pulses", 32'(vcount - vc), 2);
        chk("R3 last frame wins", 32'(cfg), 32'h00001);

        idle(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule